// File: doc/BRIEF.md
# Trap Entry State Sequencer

This block performs the privileged-state update that a 64-bit RISC processor carries out when it takes a trap. A one-cycle request strobe carries a 9-bit trap type, and the current condition codes, address space identifier, processor state word, window pointer, free-window count, program counters, trap level and trap base are presented alongside it. On the following clock edge the block publishes the new trap level, the new processor state word, the adjusted window pointer and the new program counter pair. It also records the state being left behind in a trap stack slot selected by the new level. A request made while the level is already at its ceiling is refused: only an error flag is raised.

A small soft-interrupt register sits beside the sequencer. It can be set by OR, cleared by AND-NOT or written whole. It emits a one-cycle recheck pulse when an operation really changes its value while interrupts are enabled.

Processor state word bit positions used throughout: 0 alternate globals, 1 interrupt enable, 2 privileged, 3 address mask, 4 FPU enable, 5 reduced-error, 7:6 memory model, 8 trap-level-zero enable, 9 current little-endian, 10 MMU globals, 11 interrupt globals.

Top module: `trap_entry_seq`

## Requirements
- R1: After reset, tlOut, pstateOut, cwpOut, pcOut, npcOut, errState, softint and recheckIrq are all zero, and every trap stack slot reads zero.
- R2: A request with tlIn below MAXTL-1 sets tlOut to tlIn+1 and copies the reduced-error bit (5) from pstateIn unchanged.
- R3: A request with tlIn equal to MAXTL-1 sets tlOut to MAXTL and sets the reduced-error bit (5) of pstateOut.
- R4: A request with tlIn at or above MAXTL sets errState and leaves tlOut, pstateOut, cwpOut, pcOut, npcOut and every stack slot unchanged; the next accepted request clears errState.
- R5: An accepted request writes into stack slot tlIn+1 a 40-bit word holding ccrIn in bits 39:32, asiIn in bits 31:24, pstateIn AND 0xF3F in bits 19:8, cwpIn zero-extended in bits 7:0, and zero in bits 23:20.
- R6: The same slot records pcIn, npcIn and the 9-bit trap type, all readable through stkSel.
- R7: Type 0x060 selects interrupt globals (bit 11). Types 0x008, 0x030 and 0x064 to 0x06F select MMU globals (bit 10). Every other type selects alternate globals (bit 0). The other two global bits are cleared, bits 2 and 4 are set, and all remaining bits come from pstateIn.
- R8: Type 0x024 gives cwpOut = cwpIn-1. Types 0x080 to 0x0BF give cwpIn-cansaveIn-2. Types 0x0C0 to 0x0FF give cwpIn+1. All results are modulo NWIN; any other type passes cwpIn through.
- R9: pcOut is tbaIn with bits 14:0 replaced: bit 14 is set when the new level exceeds 1, bits 13:5 hold the trap type, and bits 4:0 are zero. npcOut equals pcOut+4.
- R10: Without a request, all trap outputs and stack slots keep their values whatever the other inputs do.
- R11: siOp 1 ORs siData into softint, 2 clears the bits set in siData, 3 loads siData, and 0 leaves softint unchanged.
- R12: recheckIrq pulses for exactly one cycle after a soft-interrupt operation that changes softint while intEnable is high, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | One-cycle trap request strobe |
| trapType | input | 9 | Trap type code |
| ccrIn | input | 8 | Current condition codes |
| asiIn | input | 8 | Current address space identifier |
| pstateIn | input | 12 | Current processor state word |
| cwpIn | input | CWW (3) | Current window pointer |
| cansaveIn | input | CWW (3) | Current free-window count |
| pcIn | input | 64 | Current program counter |
| npcIn | input | 64 | Current next program counter |
| tlIn | input | TLW (3) | Current trap level |
| tbaIn | input | 64 | Trap base register |
| stkSel | input | TLW (3) | Trap stack slot to read |
| siOp | input | 2 | Soft-interrupt operation: 0 none, 1 set, 2 clear, 3 write |
| siData | input | SIW (16) | Soft-interrupt operand |
| intEnable | input | 1 | Interrupts enabled |
| tlOut | output | TLW (3) | New trap level |
| pstateOut | output | 12 | New processor state word |
| cwpOut | output | CWW (3) | New window pointer |
| pcOut | output | 64 | Trap vector address |
| npcOut | output | 64 | Trap vector address plus 4 |
| errState | output | 1 | Request refused at maximum level |
| stkState | output | 40 | Saved state word of the selected slot |
| stkPc | output | 64 | Saved PC of the selected slot |
| stkNpc | output | 64 | Saved next PC of the selected slot |
| stkType | output | 9 | Saved trap type of the selected slot |
| softint | output | SIW (16) | Soft-interrupt register |
| recheckIrq | output | 1 | Pulse asking for an interrupt re-evaluation |

## Verification
The hardest situations to reach are the window pointer underflowing through the spill formula and the entry at level MAXTL-1 that both raises the reduced-error bit and fills the last stack slot. Reaching them from the ports depends on what is driven on tlIn, cwpIn and cansaveIn. The bench drives cwpIn=1 with cansaveIn=6 on a spill type, so the result wraps through zero. It then issues a request at level 4 followed by one at level 5. This shows that the refused request leaves the slot written by the reduced-error entry intact.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int PS_AG   = 0;
  localparam int PS_PRIV = 2;
  localparam int PS_PEF  = 4;
  localparam int PS_RED  = 5;
  localparam int PS_MG   = 10;
  localparam int PS_IG   = 11;
  localparam logic [11:0] PS_SAVE_MASK = 12'hF3F;

  localparam logic [8:0] TT_IVEC   = 9'h060;
  localparam logic [8:0] TT_IFAULT = 9'h008;
  localparam logic [8:0] TT_DFAULT = 9'h030;
  localparam logic [8:0] TT_CLEAN  = 9'h024;

  typedef enum logic [1:0] {GL_ALT, GL_MMU, GL_INT} globSel_e;
  typedef enum logic [1:0] {WIN_KEEP, WIN_CLEAN, WIN_SPILL, WIN_FILL} winMode_e;

  typedef struct packed {
    logic     doEntry;
    logic     doErr;
    logic     enterRed;
    globSel_e glob;
    winMode_e win;
  } trapCtl_t;
endpackage

// File: rtl/trap_ctrl.sv
module trap_ctrl
  import trap_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int TLW   = 3
) (
  input  logic           trapReq,
  input  logic [8:0]     trapType,
  input  logic [TLW-1:0] tlIn,
  output trapCtl_t       ctl
);
  localparam logic [TLW-1:0] TL_CEIL = TLW'(MAXTL);
  localparam logic [TLW-1:0] TL_LAST = TLW'(MAXTL - 1);

  logic isMmu;
  assign isMmu = (trapType == TT_IFAULT) || (trapType == TT_DFAULT) ||
                 (trapType >= 9'h064 && trapType <= 9'h06F);

  always_comb begin
    ctl.doErr    = trapReq && (tlIn >= TL_CEIL);
    ctl.doEntry  = trapReq && !(tlIn >= TL_CEIL);
    ctl.enterRed = (tlIn == TL_LAST);
    if (trapType == TT_IVEC)  ctl.glob = GL_INT;
    else if (isMmu)           ctl.glob = GL_MMU;
    else                      ctl.glob = GL_ALT;
    if (trapType == TT_CLEAN)          ctl.win = WIN_CLEAN;
    else if (trapType[8:6] == 3'b010)  ctl.win = WIN_SPILL;
    else if (trapType[8:6] == 3'b011)  ctl.win = WIN_FILL;
    else                               ctl.win = WIN_KEEP;
  end
endmodule

// File: rtl/trap_dp.sv
module trap_dp
  import trap_pkg::*;
#(
  parameter int MAXTL = 5,
  parameter int TLW   = 3,
  parameter int CWW   = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  trapCtl_t       ctl,
  input  logic [8:0]     trapType,
  input  logic [7:0]     ccrIn,
  input  logic [7:0]     asiIn,
  input  logic [11:0]    pstateIn,
  input  logic [CWW-1:0] cwpIn,
  input  logic [CWW-1:0] cansaveIn,
  input  logic [63:0]    pcIn,
  input  logic [63:0]    npcIn,
  input  logic [TLW-1:0] tlIn,
  input  logic [63:0]    tbaIn,
  input  logic [TLW-1:0] stkSel,
  output logic [TLW-1:0] tlOut,
  output logic [11:0]    pstateOut,
  output logic [CWW-1:0] cwpOut,
  output logic [63:0]    pcOut,
  output logic [63:0]    npcOut,
  output logic           errState,
  output logic [39:0]    stkState,
  output logic [63:0]    stkPc,
  output logic [63:0]    stkNpc,
  output logic [8:0]     stkType
);
  localparam int DEPTH = MAXTL + 1;

  logic [39:0] slotState [DEPTH];
  logic [63:0] slotPc    [DEPTH];
  logic [63:0] slotNpc   [DEPTH];
  logic [8:0]  slotType  [DEPTH];

  logic [TLW-1:0] tlNew;
  logic [39:0]    savedWord;
  logic [CWW-1:0] cwpNew;
  logic [11:0]    pstateNew;
  logic [63:0]    vecAddr;

  assign tlNew     = tlIn + TLW'(1);
  assign savedWord = {ccrIn, asiIn, 4'b0000, pstateIn & PS_SAVE_MASK, 8'(cwpIn)};
  assign vecAddr   = {tbaIn[63:15], tlNew > TLW'(1), trapType, 5'b00000};

  always_comb begin
    case (ctl.win)
      WIN_CLEAN: cwpNew = cwpIn - CWW'(1);
      WIN_SPILL: cwpNew = cwpIn - cansaveIn - CWW'(2);
      WIN_FILL:  cwpNew = cwpIn + CWW'(1);
      default:   cwpNew = cwpIn;
    endcase
  end

  always_comb begin
    pstateNew          = pstateIn;
    pstateNew[PS_AG]   = (ctl.glob == GL_ALT);
    pstateNew[PS_MG]   = (ctl.glob == GL_MMU);
    pstateNew[PS_IG]   = (ctl.glob == GL_INT);
    pstateNew[PS_PEF]  = 1'b1;
    pstateNew[PS_PRIV] = 1'b1;
    if (ctl.enterRed) pstateNew[PS_RED] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tlOut     <= '0;
      pstateOut <= '0;
      cwpOut    <= '0;
      pcOut     <= '0;
      npcOut    <= '0;
      errState  <= 1'b0;
    end else if (ctl.doErr) begin
      errState  <= 1'b1;
    end else if (ctl.doEntry) begin
      errState  <= 1'b0;
      tlOut     <= tlNew;
      pstateOut <= pstateNew;
      cwpOut    <= cwpNew;
      pcOut     <= vecAddr;
      npcOut    <= vecAddr + 64'd4;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotState[g] <= '0;
        slotPc[g]    <= '0;
        slotNpc[g]   <= '0;
        slotType[g]  <= '0;
      end else if (ctl.doEntry && tlNew == TLW'(g)) begin
        slotState[g] <= savedWord;
        slotPc[g]    <= pcIn;
        slotNpc[g]   <= npcIn;
        slotType[g]  <= trapType;
      end
    end
  end

  always_comb begin
    stkState = '0;
    stkPc    = '0;
    stkNpc   = '0;
    stkType  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (stkSel == TLW'(i)) begin
        stkState = slotState[i];
        stkPc    = slotPc[i];
        stkNpc   = slotNpc[i];
        stkType  = slotType[i];
      end
    end
  end
endmodule

// File: rtl/softint_reg.sv
module softint_reg #(
  parameter int SIW = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [1:0]     siOp,
  input  logic [SIW-1:0] siData,
  input  logic           intEnable,
  output logic [SIW-1:0] softint,
  output logic           recheckIrq
);
  logic [SIW-1:0] nextVal;

  always_comb begin
    case (siOp)
      2'd1:    nextVal = softint | siData;
      2'd2:    nextVal = softint & ~siData;
      2'd3:    nextVal = siData;
      default: nextVal = softint;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      softint    <= '0;
      recheckIrq <= 1'b0;
    end else begin
      softint    <= nextVal;
      recheckIrq <= (nextVal != softint) && intEnable;
    end
  end
endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int MAXTL = 5,
  parameter int SIW   = 16,
  localparam int CWW  = $clog2(NWIN),
  localparam int TLW  = $clog2(MAXTL + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           trapReq,
  input  logic [8:0]     trapType,
  input  logic [7:0]     ccrIn,
  input  logic [7:0]     asiIn,
  input  logic [11:0]    pstateIn,
  input  logic [CWW-1:0] cwpIn,
  input  logic [CWW-1:0] cansaveIn,
  input  logic [63:0]    pcIn,
  input  logic [63:0]    npcIn,
  input  logic [TLW-1:0] tlIn,
  input  logic [63:0]    tbaIn,
  input  logic [TLW-1:0] stkSel,
  input  logic [1:0]     siOp,
  input  logic [SIW-1:0] siData,
  input  logic           intEnable,
  output logic [TLW-1:0] tlOut,
  output logic [11:0]    pstateOut,
  output logic [CWW-1:0] cwpOut,
  output logic [63:0]    pcOut,
  output logic [63:0]    npcOut,
  output logic           errState,
  output logic [39:0]    stkState,
  output logic [63:0]    stkPc,
  output logic [63:0]    stkNpc,
  output logic [8:0]     stkType,
  output logic [SIW-1:0] softint,
  output logic           recheckIrq
);
  trapCtl_t ctl;

  trap_ctrl #(.MAXTL(MAXTL), .TLW(TLW)) uCtrl (
    .trapReq(trapReq), .trapType(trapType), .tlIn(tlIn), .ctl(ctl)
  );

  trap_dp #(.MAXTL(MAXTL), .TLW(TLW), .CWW(CWW)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .trapType(trapType),
    .ccrIn(ccrIn), .asiIn(asiIn), .pstateIn(pstateIn), .cwpIn(cwpIn),
    .cansaveIn(cansaveIn), .pcIn(pcIn), .npcIn(npcIn), .tlIn(tlIn),
    .tbaIn(tbaIn), .stkSel(stkSel), .tlOut(tlOut), .pstateOut(pstateOut),
    .cwpOut(cwpOut), .pcOut(pcOut), .npcOut(npcOut), .errState(errState),
    .stkState(stkState), .stkPc(stkPc), .stkNpc(stkNpc), .stkType(stkType)
  );

  softint_reg #(.SIW(SIW)) uSoft (
    .clk(clk), .rstN(rstN), .siOp(siOp), .siData(siData),
    .intEnable(intEnable), .softint(softint), .recheckIrq(recheckIrq)
  );
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int MAXTL = 5,
  parameter int TLW   = 3
) (
  input logic           clk,
  input logic           rstN,
  input logic           trapReq,
  input logic [8:0]     trapType,
  input logic [TLW-1:0] tlIn,
  input logic           intEnable,
  input logic [TLW-1:0] tlOut,
  input logic [11:0]    pstateOut,
  input logic [63:0]    pcOut,
  input logic [63:0]    npcOut,
  input logic           errState,
  input logic           recheckIrq
);
  logic accept, refuse;
  assign refuse = trapReq && (tlIn >= TLW'(MAXTL));
  assign accept = trapReq && !(tlIn >= TLW'(MAXTL));

  assert_tl_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    tlOut <= TLW'(MAXTL));

  assert_red_entry_R3: assert property (@(posedge clk) disable iff (!rstN)
    accept && tlIn == TLW'(MAXTL - 1) |=> pstateOut[5] && tlOut == TLW'(MAXTL));

  assert_refuse_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    refuse |=> errState && $stable(tlOut) && $stable(pcOut) && $stable(pstateOut));

  assert_glob_onehot_R7: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> $onehot({pstateOut[11], pstateOut[10], pstateOut[0]}) &&
               pstateOut[2] && pstateOut[4]);

  assert_vector_R9: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> pcOut[13:5] == $past(trapType) && pcOut[4:0] == 5'd0 &&
               npcOut == pcOut + 64'd4);

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |=> $stable(tlOut) && $stable(pcOut) && $stable(pstateOut) &&
                 $stable(errState));

  assert_recheck_enable_R12: assert property (@(posedge clk) disable iff (!rstN)
    recheckIrq |-> $past(intEnable));
endmodule

bind trap_entry_seq trap_entry_chk #(.MAXTL(MAXTL), .TLW(TLW)) uChk (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
  .tlIn(tlIn), .intEnable(intEnable), .tlOut(tlOut), .pstateOut(pstateOut),
  .pcOut(pcOut), .npcOut(npcOut), .errState(errState), .recheckIrq(recheckIrq)
);

// File: tb/trap_entry_seq_test.sv
module trap_entry_seq_test;
  localparam int MAXTL = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic [8:0]  trapType = '0;
  logic [7:0]  ccrIn = '0, asiIn = '0;
  logic [11:0] pstateIn = '0;
  logic [2:0]  cwpIn = '0, cansaveIn = '0, tlIn = '0, stkSel = '0;
  logic [63:0] pcIn = '0, npcIn = '0, tbaIn = '0;
  logic [1:0]  siOp = '0;
  logic [15:0] siData = '0;
  logic        intEnable = 1'b0;
  logic [2:0]  tlOut, cwpOut;
  logic [11:0] pstateOut;
  logic [63:0] pcOut, npcOut, stkPc, stkNpc;
  logic        errState, recheckIrq;
  logic [39:0] stkState;
  logic [8:0]  stkType;
  logic [15:0] softint;

  int nChecks = 0;
  int nFails  = 0;

  trap_entry_seq uut (.*);

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic runTrap(input logic [8:0] tt, input logic [2:0] tl, input logic [2:0] cwp,
                         input logic [2:0] cans, input logic [11:0] ps);
    logic [2:0]  expTl, expCwp;
    logic [11:0] expPs;
    logic [63:0] expPc;
    logic [39:0] expWord;
    expTl = tl + 3'd1;
    expPs = ps & ~12'hC01;
    if (tt == 9'h060) expPs[11] = 1'b1;
    else if (tt == 9'h008 || tt == 9'h030 || (tt >= 9'h064 && tt <= 9'h06F)) expPs[10] = 1'b1;
    else expPs[0] = 1'b1;
    expPs = expPs | 12'h014;
    if (tl == 3'(MAXTL - 1)) expPs[5] = 1'b1;
    if (tt == 9'h024) expCwp = 3'((int'(cwp) + 7) % 8);
    else if (tt >= 9'h080 && tt <= 9'h0BF) expCwp = 3'((int'(cwp) - int'(cans) - 2 + 16) % 8);
    else if (tt >= 9'h0C0 && tt <= 9'h0FF) expCwp = 3'((int'(cwp) + 1) % 8);
    else expCwp = cwp;
    expPc = {tbaIn[63:15], 15'd0} | (expTl > 3'd1 ? 64'h4000 : 64'd0) | (64'(tt) << 5);
    expWord = {ccrIn, asiIn, 4'd0, ps & 12'hF3F, 5'd0, cwp};
    @(negedge clk);
    trapType = tt; tlIn = tl; cwpIn = cwp; cansaveIn = cans; pstateIn = ps;
    trapReq = 1'b1;
    @(negedge clk);
    trapReq = 1'b0;
    stkSel = expTl;
    #0.5;
    check("R2 tlOut", 64'(tlOut), 64'(expTl));
    check("R7 pstateOut", 64'(pstateOut), 64'(expPs));
    check("R8 cwpOut", 64'(cwpOut), 64'(expCwp));
    check("R9 pcOut", pcOut, expPc);
    check("R9 npcOut", npcOut, expPc + 64'd4);
    check("R4 errState cleared", 64'(errState), 64'd0);
    check("R5 saved word", 64'(stkState), 64'(expWord));
    check("R6 saved pc", stkPc, pcIn);
    check("R6 saved npc", stkNpc, npcIn);
    check("R6 saved type", 64'(stkType), 64'(tt));
  endtask

  task automatic testReset();
    check("R1 tlOut", 64'(tlOut), 64'd0);
    check("R1 pcOut", pcOut, 64'd0);
    check("R1 pstateOut", 64'(pstateOut), 64'd0);
    check("R1 errState", 64'(errState), 64'd0);
    check("R1 softint", 64'(softint), 64'd0);
    check("R1 recheckIrq", 64'(recheckIrq), 64'd0);
    for (int i = 0; i <= MAXTL; i++) begin
      stkSel = 3'(i);
      #0.1;
      check("R1 stack slot", 64'(stkState) | stkPc | 64'(stkType), 64'd0);
    end
  endtask

  task automatic testNormal();
    ccrIn = 8'hA5; asiIn = 8'h3C; pcIn = 64'h1234_5678_9ABC_DEF0;
    npcIn = 64'h1234_5678_9ABC_DEF4; tbaIn = 64'hFFFF_0000_ABCD_8123;
    runTrap(9'h010, 3'd0, 3'd2, 3'd1, 12'hFE2);
    runTrap(9'h060, 3'd1, 3'd3, 3'd0, 12'h0C0);
    runTrap(9'h065, 3'd2, 3'd4, 3'd2, 12'h301);
    runTrap(9'h008, 3'd0, 3'd5, 3'd0, 12'h020);
    runTrap(9'h030, 3'd1, 3'd6, 3'd0, 12'h000);
    runTrap(9'h06F, 3'd0, 3'd0, 3'd0, 12'h800);
    runTrap(9'h070, 3'd0, 3'd0, 3'd0, 12'h400);
    runTrap(9'h100, 3'd2, 3'd5, 3'd3, 12'h002);
  endtask

  task automatic testWindows();
    runTrap(9'h024, 3'd0, 3'd0, 3'd0, 12'h000);
    runTrap(9'h084, 3'd1, 3'd1, 3'd6, 12'h000);
    runTrap(9'h0BF, 3'd0, 3'd7, 3'd1, 12'h000);
    runTrap(9'h0C8, 3'd2, 3'd7, 3'd0, 12'h000);
  endtask

  task automatic testRedAndRefuse();
    logic [63:0] keepPc;
    logic [11:0] keepPs;
    logic [63:0] keepSlot;
    pcIn = 64'h0000_0000_4000_1000; npcIn = 64'h0000_0000_4000_1004;
    runTrap(9'h041, 3'(MAXTL - 1), 3'd2, 3'd0, 12'h000);
    check("R3 tl at ceiling", 64'(tlOut), 64'(MAXTL));
    check("R3 red bit", 64'(pstateOut[5]), 64'd1);
    keepPc = pcOut; keepPs = pstateOut; keepSlot = stkPc;
    @(negedge clk);
    pcIn = 64'hDEAD_BEEF_0000_0000; trapType = 9'h011; tlIn = 3'(MAXTL);
    trapReq = 1'b1;
    @(negedge clk);
    trapReq = 1'b0;
    stkSel = 3'(MAXTL);
    #0.5;
    check("R4 errState", 64'(errState), 64'd1);
    check("R4 tl kept", 64'(tlOut), 64'(MAXTL));
    check("R4 pc kept", pcOut, keepPc);
    check("R4 pstate kept", 64'(pstateOut), 64'(keepPs));
    check("R4 slot kept", stkPc, keepSlot);
    check("R4 slot type kept", 64'(stkType), 64'h041);
    runTrap(9'h012, 3'd0, 3'd1, 3'd0, 12'h000);
  endtask

  task automatic testHold();
    logic [63:0] keepPc, keepSlot;
    logic [2:0]  keepTl, keepCwp;
    keepPc = pcOut; keepTl = tlOut; keepCwp = cwpOut;
    stkSel = 3'd1;
    #0.1;
    keepSlot = stkPc;
    @(negedge clk);
    tbaIn = 64'h5555_5555_5555_5555; tlIn = 3'd3; cwpIn = 3'd6;
    trapType = 9'h0C0; pcIn = 64'h77;
    repeat (3) @(negedge clk);
    #0.5;
    check("R10 pc held", pcOut, keepPc);
    check("R10 tl held", 64'(tlOut), 64'(keepTl));
    check("R10 cwp held", 64'(cwpOut), 64'(keepCwp));
    check("R10 slot held", stkPc, keepSlot);
  endtask

  task automatic siStep(input logic [1:0] op, input logic [15:0] d, input logic en,
                        input logic [15:0] expVal, input logic expPulse, input string tag);
    @(negedge clk);
    siOp = op; siData = d; intEnable = en;
    @(negedge clk);
    siOp = 2'd0;
    #0.5;
    check(tag, 64'(softint), 64'(expVal));
    check("R12 recheck pulse", 64'(recheckIrq), 64'(expPulse));
    @(negedge clk);
    #0.5;
    check("R12 pulse ends", 64'(recheckIrq), 64'd0);
  endtask

  task automatic testSoftint();
    siStep(2'd1, 16'h0012, 1'b1, 16'h0012, 1'b1, "R11 set");
    siStep(2'd1, 16'h0002, 1'b1, 16'h0012, 1'b0, "R11 set no change");
    siStep(2'd2, 16'h0010, 1'b1, 16'h0002, 1'b1, "R11 clear");
    siStep(2'd3, 16'hA000, 1'b0, 16'hA000, 1'b0, "R11 write disabled");
    siStep(2'd0, 16'hFFFF, 1'b1, 16'hA000, 1'b0, "R11 no op");
    siStep(2'd3, 16'h0001, 1'b1, 16'h0001, 1'b1, "R11 write");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #0.5;
    testReset();
    testNormal();
    testWindows();
    testRedAndRefuse();
    testHold();
    testSoftint();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule